// File: doc/BRIEF.md
# Raster 3x3 Neighbourhood Window Generator

This block accepts a raster-scanned stream of pixels. Each pixel arrives with a valid strobe, a line-start marker and a frame-start marker. Two complete video lines are held in line-length storage. A column counter that restarts on every line-start marker addresses that storage. A three-column shift stage joins the two stored lines with the incoming line. From them the block presents a full 3x3 neighbourhood whose centre is the pixel one line and one column behind the input.

The line-start and frame-start markers leave the block re-timed to the window centre. The delay from input to output is fixed at one line plus one pixel of accepted data, whatever follows downstream. Stages can therefore be chained, split and merged without any frame store. Neighbour positions that fall outside the image are filled with zero. A flag reports when the window lies wholly inside the image. Cycles in which the valid strobe is low never advance the window.

Top module: `nbhd_window3`

## Requirements
- R1: After reset, pixels count from the first `frame_start`. When `win_vld` is high, the centre entry (entry 4, also on `ctr_pix`) equals the pixel accepted exactly LINE_LEN+1 accepted pixels before the most recent accepted one. Entry k of `win` sits at bits [k*PIX_W +: PIX_W], with k = 3*row + column, row 0 on top and column 0 on the left.
- R2: Every non-centre entry equals the image pixel at the matching row and column offset (-1, 0 or +1) from the centre, within the centre's own frame.
- R3: Entries 0, 3 and 6 are zero when the centre lies in column 0. Entries 2, 5 and 8 are zero when the centre lies in column LINE_LEN-1.
- R4: Entries 0, 1 and 2 are zero when the centre lies in the first row of a frame. Entries 6, 7 and 8 are zero when the centre lies in the last row of a frame. The last row of a frame is the row whose successor line begins with `frame_start`.
- R5: `win_full` is high exactly when `win_vld` is high and the centre lies in neither the first or last row nor the first or last column.
- R6: `ctr_line_start` is high exactly when `win_vld` is high and the centre is in column 0. `ctr_frame_start` is high exactly when, in addition, the centre is in row 0. Both markers therefore lag the input markers by LINE_LEN+1 accepted pixels.
- R7: A cycle with `pix_vld` low is followed by a cycle with `win_vld` low, and in that cycle `win` is unchanged from the cycle before.
- R8: Out of reset, `win_vld`, `win_full` and both output markers are low and `win` is all zero. `win_vld` stays low until LINE_LEN+1 pixels have been accepted after the first `frame_start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_vld | input | 1 | Input pixel is present this cycle |
| pix_in | input | PIX_W | Input pixel value |
| line_start | input | 1 | Input pixel is the first of a line |
| frame_start | input | 1 | Input pixel is the first of a frame (also a line start) |
| win_vld | output | 1 | Window is valid; high for one cycle after each accepted pixel whose centre exists |
| win | output | 9*PIX_W | 3x3 neighbourhood, row-major, entry 4 is the centre |
| ctr_pix | output | PIX_W | Centre pixel of the window |
| ctr_line_start | output | 1 | Centre is the first pixel of its line |
| ctr_frame_start | output | 1 | Centre is the first pixel of its frame |
| win_full | output | 1 | No window position is zero-filled |

## Verification
A column edge and a row edge can apply to the same window at once, at the four image corners. The left-column zero fill also coincides with the re-timed line-start and frame-start markers on every row-0 column-0 centre. The bench sweeps every centre position of several consecutive small frames, with blanking cycles placed at line ends and in mid-line. Each corner window must show the union of the row and column zero patterns. The bench computes the expected window, the markers and the inside flag arithmetically from the frame geometry, and compares all of them in the same sample.

// File: rtl/win3_pkg.sv
package win3_pkg;

  // Which line of the current frame the input pixel belongs to.
  typedef enum logic [1:0] {
    ROW_FIRST  = 2'd0,
    ROW_SECOND = 2'd1,
    ROW_LATER  = 2'd2
  } row_phase_e;

  // Row phase of the incoming pixel given the stored phase and its markers.
  function automatic row_phase_e row_step(input row_phase_e cur, input logic sof,
                                          input logic sol);
    if (sof) return ROW_FIRST;
    if (sol) return (cur == ROW_FIRST) ? ROW_SECOND : ROW_LATER;
    return cur;
  endfunction

  // Column index after cur, wrapping at len.
  function automatic int unsigned col_step(input int unsigned cur, input int unsigned len);
    return (cur + 1 >= len) ? 0 : cur + 1;
  endfunction

endpackage

// File: rtl/raster_pos.sv
module raster_pos
  import win3_pkg::*;
#(
  parameter int LINE_LEN = 512,
  localparam int COL_W = $clog2(LINE_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc,
  input  logic             sol,
  input  logic             sof,
  output logic [COL_W-1:0] cur_col,
  output row_phase_e       cur_phase,
  output logic             cur_ok
);

  logic [COL_W-1:0] col_q;
  row_phase_e       row_q;
  logic             act_q, two_q;
  logic             act_n, two_n;

  assign cur_col   = (sol || sof) ? '0 : col_q;
  assign cur_phase = row_step(row_q, sof, sol || sof);
  assign act_n     = act_q | sof;
  assign two_n     = sof ? act_q : two_q;
  // The column's centre (one line above) exists.
  assign cur_ok    = act_n && ((cur_phase != ROW_FIRST) || two_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q <= '0;
      row_q <= ROW_FIRST;
      act_q <= 1'b0;
      two_q <= 1'b0;
    end else if (acc) begin
      col_q <= COL_W'(col_step(int'(cur_col), LINE_LEN));
      row_q <= cur_phase;
      act_q <= act_n;
      two_q <= two_n;
    end
  end

endmodule

// File: rtl/line_pair.sv
module line_pair #(
  parameter int PIX_W    = 8,
  parameter int LINE_LEN = 512,
  localparam int COL_W = $clog2(LINE_LEN)
) (
  input  logic             clk,
  input  logic             acc,
  input  logic [COL_W-1:0] col,
  input  logic [PIX_W-1:0] pix,
  output logic [PIX_W-1:0] up1,
  output logic [PIX_W-1:0] up2
);

  logic [PIX_W-1:0] line_a [LINE_LEN];
  logic [PIX_W-1:0] line_b [LINE_LEN];

  assign up1 = line_a[col];
  assign up2 = line_b[col];

  always_ff @(posedge clk) begin
    if (acc) begin
      line_a[col] <= pix;
      line_b[col] <= line_a[col];
    end
  end

endmodule

// File: rtl/win_shift.sv
module win_shift
  import win3_pkg::*;
#(
  parameter int PIX_W    = 8,
  parameter int LINE_LEN = 512,
  localparam int COL_W = $clog2(LINE_LEN),
  localparam logic [COL_W-1:0] LAST_COL = COL_W'(LINE_LEN - 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               acc,
  input  logic [PIX_W-1:0]   in_top,
  input  logic [PIX_W-1:0]   in_mid,
  input  logic [PIX_W-1:0]   in_bot,
  input  logic [COL_W-1:0]   in_col,
  input  row_phase_e         in_phase,
  input  logic               in_ok,
  output logic [9*PIX_W-1:0] win,
  output logic [COL_W-1:0]   c_col,
  output row_phase_e         c_phase,
  output logic               c_ok,
  output logic               c_inner
);

  logic [PIX_W-1:0] px [3][3];  // [stage][row], stage 0 newest
  logic [COL_W-1:0] col0, col1;
  row_phase_e       ph0, ph1;
  logic             ok0, ok1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < 3; s++)
        for (int r = 0; r < 3; r++) px[s][r] <= '0;
      col0 <= '0; col1 <= '0;
      ph0  <= ROW_FIRST; ph1 <= ROW_FIRST;
      ok0  <= 1'b0; ok1 <= 1'b0;
    end else if (acc) begin
      px[0][0] <= in_top;
      px[0][1] <= in_mid;
      px[0][2] <= in_bot;
      for (int s = 1; s < 3; s++)
        for (int r = 0; r < 3; r++) px[s][r] <= px[s-1][r];
      col0 <= in_col;   col1 <= col0;
      ph0  <= in_phase; ph1  <= ph0;
      ok0  <= in_ok;    ok1  <= ok0;
    end
  end

  logic e_left, e_right, e_top, e_bot;
  assign e_left  = (col1 == '0);
  assign e_right = (col1 == LAST_COL);
  assign e_top   = (ph1 == ROW_SECOND);
  assign e_bot   = (ph1 == ROW_FIRST);

  assign c_col   = col1;
  assign c_phase = ph1;
  assign c_ok    = ok1;
  assign c_inner = !(e_left || e_right || e_top || e_bot);

  for (genvar gr = 0; gr < 3; gr++) begin : g_row
    for (genvar gc = 0; gc < 3; gc++) begin : g_col
      logic zero;
      assign zero = ((gc == 0) && e_left) || ((gc == 2) && e_right) ||
                    ((gr == 0) && e_top)  || ((gr == 2) && e_bot);
      assign win[(gr*3+gc)*PIX_W +: PIX_W] = zero ? '0 : px[2-gc][gr];
    end
  end

endmodule

// File: rtl/nbhd_window3.sv
module nbhd_window3
  import win3_pkg::*;
#(
  parameter int PIX_W    = 8,
  parameter int LINE_LEN = 512,
  localparam int COL_W = $clog2(LINE_LEN)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pix_vld,
  input  logic [PIX_W-1:0]   pix_in,
  input  logic               line_start,
  input  logic               frame_start,
  output logic               win_vld,
  output logic [9*PIX_W-1:0] win,
  output logic [PIX_W-1:0]   ctr_pix,
  output logic               ctr_line_start,
  output logic               ctr_frame_start,
  output logic               win_full
);

  logic [COL_W-1:0] cur_col, c_col;
  row_phase_e       cur_phase, c_phase;
  logic             cur_ok, c_ok, c_inner;
  logic [PIX_W-1:0] up1, up2;
  logic             adv;

  raster_pos #(.LINE_LEN(LINE_LEN)) u_pos (
    .clk(clk), .rst_n(rst_n), .acc(pix_vld), .sol(line_start), .sof(frame_start),
    .cur_col(cur_col), .cur_phase(cur_phase), .cur_ok(cur_ok)
  );

  line_pair #(.PIX_W(PIX_W), .LINE_LEN(LINE_LEN)) u_lines (
    .clk(clk), .acc(pix_vld), .col(cur_col), .pix(pix_in), .up1(up1), .up2(up2)
  );

  win_shift #(.PIX_W(PIX_W), .LINE_LEN(LINE_LEN)) u_shift (
    .clk(clk), .rst_n(rst_n), .acc(pix_vld),
    .in_top(up2), .in_mid(up1), .in_bot(pix_in),
    .in_col(cur_col), .in_phase(cur_phase), .in_ok(cur_ok),
    .win(win), .c_col(c_col), .c_phase(c_phase), .c_ok(c_ok), .c_inner(c_inner)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) adv <= 1'b0;
    else        adv <= pix_vld;
  end

  assign win_vld         = adv && c_ok;
  assign ctr_pix         = win[4*PIX_W +: PIX_W];
  assign ctr_line_start  = win_vld && (c_col == '0);
  assign ctr_frame_start = ctr_line_start && (c_phase == ROW_SECOND);
  assign win_full        = win_vld && c_inner;

endmodule

// File: rtl/nbhd_window3_chk.sv
module nbhd_window3_chk #(
  parameter int PIX_W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               pix_vld,
  input logic               win_vld,
  input logic [9*PIX_W-1:0] win,
  input logic               ctr_line_start,
  input logic               ctr_frame_start,
  input logic               win_full
);

  p_vld_after_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    win_vld |-> $past(pix_vld));

  p_blank_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(pix_vld) |-> (!win_vld && $stable(win)));

  p_frame_in_line_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ctr_frame_start |-> ctr_line_start);

  p_full_not_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
    win_full |-> (win_vld && !ctr_line_start));

  p_left_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ctr_line_start |-> (win[0 +: PIX_W] == '0 && win[3*PIX_W +: PIX_W] == '0 &&
                        win[6*PIX_W +: PIX_W] == '0));

  p_top_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ctr_frame_start |-> (win[0 +: 3*PIX_W] == '0));

endmodule

bind nbhd_window3 nbhd_window3_chk #(.PIX_W(PIX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pix_vld(pix_vld), .win_vld(win_vld), .win(win),
  .ctr_line_start(ctr_line_start), .ctr_frame_start(ctr_frame_start), .win_full(win_full)
);

// File: tb/test_nbhd_window3.sv
`timescale 1ns/1ps
module test_nbhd_window3;

  localparam int PW = 8;
  localparam int L  = 5;   // pixels per line
  localparam int H  = 4;   // lines per frame (bench only)
  localparam int NF = 4;   // frames sent
  localparam int N  = L * H * NF;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          pix_vld = 1'b0;
  logic [PW-1:0] pix_in = '0;
  logic          line_start = 1'b0;
  logic          frame_start = 1'b0;
  logic          win_vld;
  logic [9*PW-1:0] win;
  logic [PW-1:0] ctr_pix;
  logic          ctr_line_start, ctr_frame_start, win_full;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  nbhd_window3 #(.PIX_W(PW), .LINE_LEN(L)) i_nbhd_window3 (
    .clk(clk), .rst_n(rst_n), .pix_vld(pix_vld), .pix_in(pix_in),
    .line_start(line_start), .frame_start(frame_start),
    .win_vld(win_vld), .win(win), .ctr_pix(ctr_pix),
    .ctr_line_start(ctr_line_start), .ctr_frame_start(ctr_frame_start),
    .win_full(win_full)
  );

  function automatic int pv(input int g);
    return ((g * 29) % 250) + 3;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  bit          last_valid = 1'b0;
  int          last_idx = 0;
  logic [9*PW-1:0] prev_win = '0;

  task automatic check_cycle();
    if (last_valid) begin
      int j = last_idx - L - 1;
      if (j < 0) begin
        chk("R8 early win_vld", win_vld, 0);
      end else begin
        int fb = (j / (L * H)) * L * H;
        int r  = (j / L) % H;
        int c  = j % L;
        chk("R1 win_vld", win_vld, 1);
        chk("R1 ctr_pix", ctr_pix, pv(j));
        for (int dr = 0; dr < 3; dr++) begin
          for (int dc = 0; dc < 3; dc++) begin
            int rr = r + dr - 1;
            int cc = c + dc - 1;
            int k  = dr * 3 + dc;
            logic [31:0] got = 32'(win[k*PW +: PW]);
            if (cc < 0 || cc >= L)      chk("R3 column fill", got, 0);
            else if (rr < 0 || rr >= H) chk("R4 row fill", got, 0);
            else if (k == 4)            chk("R1 centre", got, pv(j));
            else                        chk("R2 neighbour", got, pv(fb + rr * L + cc));
          end
        end
        chk("R6 line marker", ctr_line_start, (c == 0) ? 1 : 0);
        chk("R6 frame marker", ctr_frame_start, (c == 0 && r == 0) ? 1 : 0);
        chk("R5 inside flag", win_full,
            (r > 0 && r < H - 1 && c > 0 && c < L - 1) ? 1 : 0);
      end
    end else begin
      chk("R7 blank win_vld", win_vld, 0);
      chk("R7 blank hold", (win == prev_win) ? 1 : 0, 1);
    end
    prev_win = win;
  endtask

  task automatic blank();
    @(negedge clk);
    check_cycle();
    pix_vld = 1'b0; line_start = 1'b0; frame_start = 1'b0; pix_in = 8'hEE;
    last_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8: reset state
    chk("R8 reset win_vld", win_vld, 0);
    chk("R8 reset win_full", win_full, 0);
    chk("R8 reset line marker", ctr_line_start, 0);
    chk("R8 reset frame marker", ctr_frame_start, 0);
    chk("R8 reset win zero", (win == '0) ? 1 : 0, 1);
    prev_win = win;
    for (int idx = 0; idx < N; idx++) begin
      if (idx % L == 0 && idx > 0) begin
        blank();
        blank();
      end
      if (idx % 7 == 3) blank();
      @(negedge clk);
      check_cycle();
      pix_vld     = 1'b1;
      pix_in      = PW'(pv(idx));
      line_start  = (idx % L == 0);
      frame_start = (idx % (L * H) == 0);
      last_valid  = 1'b1;
      last_idx    = idx;
    end
    repeat (3) blank();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule